// File: doc/BRIEF.md
# Windowed Register File with Global Registers

This block is the integer register file of a pipelined core whose procedures each work in a private window of registers. Software addresses 32 logical registers. A current window pointer translates each logical number into a physical slot, so a procedure call or return only moves the pointer and needs no register save to memory. Windows sit on a ring. The registers a caller fills as outgoing arguments are physically the same registers the callee reads as incoming arguments, so parameters pass without copying. A small global group is shared by every window.

There are two combinational read ports and one write port. A write in the same cycle as a read of the same physical slot is bypassed to that read. Call and return strobes move the pointer. A small frame-occupancy state machine raises an overflow flag when a call would clobber a live frame. It raises an underflow flag when a return has no caller frame to go back to. In both cases the pointer holds still. Moving frames to and from memory is left to the surrounding core.

The occupancy machine has three states. FR_ROOT means only the outermost frame is live. FR_NESTED means more than one frame is live and another call still fits. FR_FULL means the deepest allowed frame is current. The transitions are:
- call moves FR_ROOT or FR_NESTED to FR_NESTED, or to FR_FULL when the new frame is the deepest one.
- return moves FR_NESTED or FR_FULL to FR_NESTED, or to FR_ROOT when it lands on window 0.
- call in FR_FULL stays put and flags overflow.
- return in FR_ROOT stays put and flags underflow.
- call and return together leave the state unchanged.

Top module: `regwin_file`

## Requirements
- R1: After reset every logical register reads zero in every window, and the current window is window 0 holding the only live frame, so an immediate return flags underflow.
- R2: Logical register 0 always reads zero on both ports, and a write to it changes nothing.
- R3: Logical registers 1 to 7 (select bits [4:3] = 0) are global: a value written in one window reads back unchanged in every other window.
- R4: Logical registers 8 to 15 (outgoing, bits [4:3] = 1) of a caller are the same storage as logical 24 to 31 (incoming, bits [4:3] = 3) of its callee, in both directions.
- R5: Logical registers 16 to 23 (local, bits [4:3] = 2) are private to each window: a callee's local writes never change the caller's locals.
- R6: The two read ports decode independent selects in the same cycle and return data combinationally.
- R7: A write to the same physical register that a port is reading in that cycle appears on that read port in the same cycle.
- R8: A write issued in the same cycle as a call or return lands in the window that was current before the pointer moves.
- R9: With NUM_WIN-1 frames live (six calls after reset for eight windows), a further call asserts win_ovf in that same cycle, and the current window does not change.
- R10: A return while only the root frame is live asserts win_unf in that cycle, and the current window does not change.
- R11: A call and a return asserted together move nothing and raise neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Procedure call strobe, advances the window |
| ret_req | input | 1 | Procedure return strobe, retreats the window |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Logical register to write |
| wr_val | input | 32 | Write data |
| rs_a_sel | input | 5 | Logical register for read port A |
| rs_a_val | output | 32 | Read port A data |
| rs_b_sel | input | 5 | Logical register for read port B |
| rs_b_val | output | 32 | Read port B data |
| win_ovf | output | 1 | Call refused, no free window |
| win_unf | output | 1 | Return refused, no caller frame |

## Verification
The bench targets several corner cases, each named with the failure it would expose:
- Parameter overlap. A map that pairs outgoing registers with the wrong neighbour loses arguments across a call.
- Local privacy. A map that aliases locals between windows shows the callee's value after the return.
- Writes that coincide with a call or return. A design that uses the new pointer lands the value one window off.
- Same-cycle bypass. A design without forwarding shows stale data on the read port.
- Refused moves. The bench fills the ring to the overflow point and returns at the root. A design that checks the flags one frame late, or moves the pointer anyway, reads back the wrong window.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;

    // Logical register groups, selected by the two top select bits.
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;

    // Frame occupancy states.
    typedef enum logic [1:0] {
        FR_ROOT   = 2'd0,
        FR_NESTED = 2'd1,
        FR_FULL   = 2'd2
    } frame_st_e;

endpackage

// File: rtl/regwin_ctl.sv
`timescale 1ns/1ps
module regwin_ctl
    import regwin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WP_W   = $clog2(NUM_WIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_req,
    input  logic            ret_req,
    output logic [WP_W-1:0] cwp,
    output logic            win_ovf,
    output logic            win_unf
);

    localparam logic [WP_W-1:0] WP_ONE  = WP_W'(1);
    localparam logic [WP_W-1:0] WP_ZERO = '0;
    localparam logic [WP_W-1:0] WP_LAST = WP_W'(NUM_WIN - 2);

    frame_st_e       st_q, st_d;
    logic [WP_W-1:0] cwp_q, cwp_d;
    logic            go_up, go_dn;

    assign go_up = call_req & ~ret_req;
    assign go_dn = ret_req & ~call_req;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FR_ROOT;
            cwp_q <= WP_ZERO;
        end else begin
            st_q  <= st_d;
            cwp_q <= cwp_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cwp_d = cwp_q;
        unique case (st_q)
            FR_ROOT: begin
                if (go_up) begin
                    cwp_d = cwp_q + WP_ONE;
                    st_d  = (cwp_d == WP_LAST) ? FR_FULL : FR_NESTED;
                end
            end
            FR_NESTED: begin
                if (go_up) begin
                    cwp_d = cwp_q + WP_ONE;
                    st_d  = (cwp_d == WP_LAST) ? FR_FULL : FR_NESTED;
                end else if (go_dn) begin
                    cwp_d = cwp_q - WP_ONE;
                    st_d  = (cwp_d == WP_ZERO) ? FR_ROOT : FR_NESTED;
                end
            end
            FR_FULL: begin
                if (go_dn) begin
                    cwp_d = cwp_q - WP_ONE;
                    st_d  = (cwp_d == WP_ZERO) ? FR_ROOT : FR_NESTED;
                end
            end
            default: begin
                st_d  = FR_ROOT;
                cwp_d = WP_ZERO;
            end
        endcase
    end

    // Outputs
    always_comb begin
        cwp     = cwp_q;
        win_ovf = 1'b0;
        win_unf = 1'b0;
        unique case (st_q)
            FR_ROOT:   win_unf = go_dn;
            FR_NESTED: ;
            FR_FULL:   win_ovf = go_up;
            default:   ;
        endcase
    end

endmodule

// File: rtl/regwin_map.sv
`timescale 1ns/1ps
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NUM_WIN  = 8,
    parameter int GRP_SIZE = 8,
    localparam int WP_W    = $clog2(NUM_WIN),
    localparam int OFF_W   = $clog2(GRP_SIZE),
    localparam int LSEL_W  = OFF_W + 2,
    localparam int PHYS_N  = GRP_SIZE * (1 + 2 * NUM_WIN),
    localparam int PIDX_W  = $clog2(PHYS_N)
) (
    input  logic [WP_W-1:0]   cwp,
    input  logic [LSEL_W-1:0] lsel,
    output logic [PIDX_W-1:0] pidx
);

    // Physical layout: globals first, then per window a local block
    // followed by an incoming block. A window's outgoing block is the
    // incoming block of the next window on the ring.
    reg_grp_e   grp;
    logic [OFF_W-1:0] off;
    int unsigned cur_w, nxt_w, base;

    always_comb begin
        grp   = reg_grp_e'(lsel[LSEL_W-1:OFF_W]);
        off   = lsel[OFF_W-1:0];
        cur_w = 32'(cwp);
        nxt_w = (cur_w == 32'(NUM_WIN - 1)) ? 32'd0 : cur_w + 32'd1;
        unique case (grp)
            GRP_GLOBAL: base = 32'd0;
            GRP_LOCAL:  base = 32'(GRP_SIZE) * (32'd1 + 32'd2 * cur_w);
            GRP_IN:     base = 32'(GRP_SIZE) * (32'd2 + 32'd2 * cur_w);
            GRP_OUT:    base = 32'(GRP_SIZE) * (32'd2 + 32'd2 * nxt_w);
            default:    base = 32'd0;
        endcase
        pidx = PIDX_W'(base + 32'(off));
    end

endmodule

// File: rtl/regwin_store.sv
`timescale 1ns/1ps
module regwin_store #(
    parameter int DATA_W = 32,
    parameter int PHYS_N = 136,
    parameter int N_RD   = 2,
    localparam int PIDX_W = $clog2(PHYS_N)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [PIDX_W-1:0]            w_pidx,
    input  logic [DATA_W-1:0]            w_data,
    input  logic [N_RD-1:0][PIDX_W-1:0]  r_pidx,
    output logic [N_RD-1:0][DATA_W-1:0]  r_data
);

    localparam logic [PIDX_W-1:0] ZERO_SLOT = '0;

    logic [DATA_W-1:0] mem [PHYS_N];
    logic              w_live;

    // Slot 0 is the hard-wired zero register.
    assign w_live = we && (w_pidx != ZERO_SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_N; i++) mem[i] <= '0;
        end else if (w_live) begin
            mem[w_pidx] <= w_data;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        always_comb begin
            if (r_pidx[p] == ZERO_SLOT)
                r_data[p] = '0;
            else if (w_live && (w_pidx == r_pidx[p]))
                r_data[p] = w_data;
            else
                r_data[p] = mem[r_pidx[p]];
        end
    end

endmodule

// File: rtl/regwin_file.sv
`timescale 1ns/1ps
module regwin_file #(
    parameter int DATA_W   = 32,
    parameter int NUM_WIN  = 8,
    parameter int GRP_SIZE = 8,
    localparam int LSEL_W  = $clog2(GRP_SIZE) + 2,
    localparam int WP_W    = $clog2(NUM_WIN),
    localparam int PHYS_N  = GRP_SIZE * (1 + 2 * NUM_WIN),
    localparam int PIDX_W  = $clog2(PHYS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              wr_en,
    input  logic [LSEL_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [LSEL_W-1:0] rs_a_sel,
    output logic [DATA_W-1:0] rs_a_val,
    input  logic [LSEL_W-1:0] rs_b_sel,
    output logic [DATA_W-1:0] rs_b_val,
    output logic              win_ovf,
    output logic              win_unf
);

    localparam int N_RD = 2;
    localparam int N_MAP = N_RD + 1;

    logic [WP_W-1:0]                cur_wp;
    logic [N_MAP-1:0][LSEL_W-1:0]   map_sel;
    logic [N_MAP-1:0][PIDX_W-1:0]   map_pidx;
    logic [N_RD-1:0][PIDX_W-1:0]    rd_pidx;
    logic [N_RD-1:0][DATA_W-1:0]    rd_data;

    regwin_ctl #(.NUM_WIN(NUM_WIN)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (call_req),
        .ret_req  (ret_req),
        .cwp      (cur_wp),
        .win_ovf  (win_ovf),
        .win_unf  (win_unf)
    );

    // Index 0 is the write port, 1.. are read ports. All use the
    // pointer before any move, which places coinciding writes (R8).
    assign map_sel = {rs_b_sel, rs_a_sel, wr_sel};

    for (genvar m = 0; m < N_MAP; m++) begin : g_map
        regwin_map #(.NUM_WIN(NUM_WIN), .GRP_SIZE(GRP_SIZE)) u_map (
            .cwp  (cur_wp),
            .lsel (map_sel[m]),
            .pidx (map_pidx[m])
        );
    end

    for (genvar r = 0; r < N_RD; r++) begin : g_rdmap
        assign rd_pidx[r] = map_pidx[r + 1];
    end

    regwin_store #(.DATA_W(DATA_W), .PHYS_N(PHYS_N), .N_RD(N_RD)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .w_pidx (map_pidx[0]),
        .w_data (wr_val),
        .r_pidx (rd_pidx),
        .r_data (rd_data)
    );

    assign rs_a_val = rd_data[0];
    assign rs_b_val = rd_data[1];

endmodule

// File: rtl/regwin_file_chk.sv
`timescale 1ns/1ps
module regwin_file_chk #(
    parameter int DATA_W  = 32,
    parameter int NUM_WIN = 8,
    parameter int LSEL_W  = 5,
    parameter int WP_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              call_req,
    input logic              ret_req,
    input logic [LSEL_W-1:0] rs_a_sel,
    input logic [DATA_W-1:0] rs_a_val,
    input logic [LSEL_W-1:0] rs_b_sel,
    input logic [DATA_W-1:0] rs_b_val,
    input logic              win_ovf,
    input logic              win_unf,
    input logic [WP_W-1:0]   cwp
);

    a_r2_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_a_sel == '0) |-> (rs_a_val == '0));

    a_r2_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_b_sel == '0) |-> (rs_b_val == '0));

    a_r9_ovf_holds_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |=> $stable(cwp));

    a_r9_ovf_only_when_deepest: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf |-> (32'(cwp) == 32'(NUM_WIN - 2)));

    a_r10_unf_holds_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |=> $stable(cwp));

    a_r10_unf_only_at_root: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf |-> (cwp == '0));

    a_r11_both_strobes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |-> (!win_ovf && !win_unf));

    a_r11_both_strobes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |=> $stable(cwp));

    a_r4_call_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req && !win_ovf) |=> (32'(cwp) == 32'($past(cwp)) + 32'd1));

    a_r4_ret_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req && !win_unf) |=> (32'(cwp) + 32'd1 == 32'($past(cwp))));

endmodule

bind regwin_file regwin_file_chk #(
    .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .LSEL_W(LSEL_W), .WP_W(WP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_req (call_req),
    .ret_req  (ret_req),
    .rs_a_sel (rs_a_sel),
    .rs_a_val (rs_a_val),
    .rs_b_sel (rs_b_sel),
    .rs_b_val (rs_b_val),
    .win_ovf  (win_ovf),
    .win_unf  (win_unf),
    .cwp      (cur_wp)
);

// File: tb/tb_regwin_file.sv
`timescale 1ns/1ps
module tb_regwin_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0;
    logic        ret_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [31:0] wr_val = '0;
    logic [4:0]  rs_a_sel = '0;
    logic [31:0] rs_a_val;
    logic [4:0]  rs_b_sel = '0;
    logic [31:0] rs_b_val;
    logic        win_ovf;
    logic        win_unf;

    int chk_cnt = 0;
    int fail_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regwin_file dut (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
        .rs_a_sel(rs_a_sel), .rs_a_val(rs_a_val),
        .rs_b_sel(rs_b_sel), .rs_b_val(rs_b_val),
        .win_ovf(win_ovf), .win_unf(win_unf)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_CALL = 2'd1, OP_RET = 2'd2, OP_CHK = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  sel;
        logic [31:0] val;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{OP_WR,   5'd1,  32'h1111_1111},  // R3 global
        '{OP_WR,   5'd8,  32'hA0A0_0008},  // R4 outgoing
        '{OP_WR,   5'd16, 32'h1000_0016},  // R5 caller local
        '{OP_CALL, 5'd0,  32'h0},
        '{OP_CHK,  5'd24, 32'hA0A0_0008},  // R4 callee incoming
        '{OP_CHK,  5'd1,  32'h1111_1111},  // R3
        '{OP_CHK,  5'd16, 32'h0},          // R5 fresh local
        '{OP_WR,   5'd16, 32'h2000_0016},
        '{OP_WR,   5'd24, 32'hB0B0_0024},
        '{OP_WR,   5'd1,  32'h2222_2222},
        '{OP_RET,  5'd0,  32'h0},
        '{OP_CHK,  5'd16, 32'h1000_0016},  // R5
        '{OP_CHK,  5'd8,  32'hB0B0_0024},  // R4 back to caller
        '{OP_CHK,  5'd1,  32'h2222_2222},  // R3
        '{OP_WR,   5'd0,  32'hDEAD_BEEF},  // R2
        '{OP_CHK,  5'd0,  32'h0}           // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        call_req = 1'b0;
        ret_req  = 1'b0;
        wr_en    = 1'b0;
    endtask

    task automatic do_wr(input logic [4:0] s, input logic [31:0] v);
        wr_en = 1'b1; wr_sel = s; wr_val = v;
        step();
    endtask

    task automatic do_call();
        call_req = 1'b1;
        step();
    endtask

    task automatic do_ret();
        ret_req = 1'b1;
        step();
    endtask

    task automatic rd_a(input string req, input logic [4:0] s, input logic [31:0] exp);
        rs_a_sel = s;
        #1;
        check(req, rs_a_val, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
            $finish;
        end
    endtask

    initial begin
        #500000;
        chk_cnt++;
        fail_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rs_a_sel = 5'd9; rs_b_sel = 5'd17;
        #1;
        check("R1 out reg", rs_a_val, 32'h0);
        check("R1 local reg", rs_b_val, 32'h0);
        ret_req = 1'b1;
        #1;
        check("R1 root underflow", {31'b0, win_unf}, 32'h1);
        step();

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            unique case (VECS[i].op)
                OP_WR:   do_wr(VECS[i].sel, VECS[i].val);
                OP_CALL: do_call();
                OP_RET:  do_ret();
                OP_CHK:  rd_a($sformatf("vector %0d", i), VECS[i].sel, VECS[i].val);
                default: ;
            endcase
        end

        // R6: both ports at once
        rs_a_sel = 5'd16; rs_b_sel = 5'd8;
        #1;
        check("R6 port A", rs_a_val, 32'h1000_0016);
        check("R6 port B", rs_b_val, 32'hB0B0_0024);

        // R7: same-cycle forwarding
        wr_en = 1'b1; wr_sel = 5'd20; wr_val = 32'h7777_0020; rs_a_sel = 5'd20;
        #1;
        check("R7 forward", rs_a_val, 32'h7777_0020);
        step();
        wr_en = 1'b1; wr_sel = 5'd0; wr_val = 32'hFFFF_FFFF; rs_b_sel = 5'd0;
        #1;
        check("R2 no forward to zero", rs_b_val, 32'h0);
        step();

        // R8: write with call uses old window
        wr_en = 1'b1; wr_sel = 5'd17; wr_val = 32'h8888_0017; call_req = 1'b1;
        step();
        rd_a("R8 call write not in callee", 5'd17, 32'h0);
        // R8: write with return uses old window
        wr_en = 1'b1; wr_sel = 5'd18; wr_val = 32'h9999_0018; ret_req = 1'b1;
        step();
        rd_a("R8 call write in caller", 5'd17, 32'h8888_0017);
        rd_a("R8 ret write not in caller", 5'd18, 32'h0);
        do_call();
        rd_a("R8 ret write in callee", 5'd18, 32'h9999_0018);
        do_ret();

        // R11: both strobes
        call_req = 1'b1; ret_req = 1'b1;
        #1;
        check("R11 flags", {30'b0, win_ovf, win_unf}, 32'h0);
        step();
        rd_a("R11 window held", 5'd16, 32'h1000_0016);

        // R10: underflow at root
        ret_req = 1'b1;
        #1;
        check("R10 flag", {31'b0, win_unf}, 32'h1);
        step();
        rd_a("R10 window held", 5'd16, 32'h1000_0016);

        // R9: fill to deepest frame
        for (int k = 0; k < 6; k++) begin
            call_req = 1'b1;
            #1;
            check("R9 no early overflow", {31'b0, win_ovf}, 32'h0);
            step();
        end
        do_wr(5'd16, 32'h6666_0016);
        rd_a("R3 global in deep window", 5'd1, 32'h2222_2222);
        call_req = 1'b1;
        #1;
        check("R9 overflow flag", {31'b0, win_ovf}, 32'h1);
        step();
        rd_a("R9 window held", 5'd16, 32'h6666_0016);
        do_ret();
        rd_a("R5 window 5 local", 5'd16, 32'h0);
        for (int k = 0; k < 5; k++) do_ret();
        rd_a("R5 root local intact", 5'd16, 32'h1000_0016);

        finish_run();
    end

endmodule